// File: doc/BRIEF.md
# Synchronous Burst SRAM

This block is a small on-chip synchronous static memory with a registered command interface and a built-in burst address generator. On every rising clock edge it samples the address, the write data, two chip enables, two start strobes, a burst step input and the write controls. A start strobe loads a new base address. The next beats of that burst are made internally, in linear or interleaved order. Each beat is either a read or a write. Writes can target single byte lanes, or every lane at once through a global write input that overrides the lane selects.

Read data leaves through one of two paths, chosen by a static mode input. The flow-through path gives the word in the cycle after the command edge. The pipelined path adds a rising-edge output register. When reads stop, the output drive turns off two edges later, in the manner of a dual-cycle deselect. An active-low output enable and an active-high sleep input act on the drive without waiting for the clock. Sleep also blocks new commands, and the array keeps its contents while asleep. The bidirectional data bus is split into `din`, `dout` and the drive flag `dout_en`.

Top module: `sync_burst_sram`

## Requirements
- R1: With `pipe_mode` low (flow-through), a read command sampled at edge k shows the addressed word on `dout` with `dout_en` high before edge k+1. Later beats follow one per cycle.
- R2: With `pipe_mode` high (pipelined), a read command sampled at edge k shows its word on `dout` with `dout_en` high before edge k+2, one beat per cycle afterwards.
- R3: With `linear_n` low, beat n of a burst (the load is beat 0, and each cycle with `step_n` low adds one) uses the base address with its two low bits replaced by (base low bits + n) mod 4.
- R4: With `linear_n` high, beat n uses the base address with its two low bits replaced by (base low bits XOR n).
- R5: When `wr_all_n` is low during an access, all four lanes of the accessed word take `din`, whatever `wr_en_n` and `lane_wr_n` are.
- R6: When `wr_all_n` is high and `wr_en_n` is low during an access, only lane i (bits 9i+8 to 9i) with `lane_wr_n[i]` low is written. The other lanes keep their contents, and no read takes place. With both high, the access is a read.
- R7: A start strobe (`start_a_n` or `start_b_n` low) starts a burst only when `ce_n` is low and `ce` is high. Otherwise it is a deselect that ends any burst and drives no data.
- R8: After the last read beat, `dout_en` stays high through the first edge that samples a non-read cycle. It falls after the second such edge.
- R9: `oe_n` high forces `dout_en` low at once, without a clock edge. Lowering it again brings the held word back.
- R10: `sleep` high forces `dout_en` low at once. Commands sampled while asleep are ignored, including writes, and the array keeps its contents. After wake-up no burst is active.
- R11: During reset `dout_en` is low and no burst is active.
- R12: A cycle with no strobe and `step_n` high inside an active burst repeats the current beat address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | 6 | Word address sampled with a start strobe |
| ce_n | input | 1 | Active-low chip enable |
| ce | input | 1 | Active-high chip enable |
| start_a_n | input | 1 | Active-low start strobe, first source |
| start_b_n | input | 1 | Active-low start strobe, second source |
| step_n | input | 1 | Active-low burst advance |
| wr_all_n | input | 1 | Active-low global write, all lanes |
| wr_en_n | input | 1 | Active-low lane write enable |
| lane_wr_n | input | 4 | Active-low per-lane write selects |
| din | input | 36 | Write data |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous active-high sleep |
| pipe_mode | input | 1 | High: pipelined output path; low: flow-through |
| linear_n | input | 1 | Low: linear burst order; high: interleaved |
| dout | output | 36 | Read data |
| dout_en | output | 1 | Data bus drive enable |

## Verification
A burst counter in the wrong state sends a beat to the wrong word. That shows as a data mismatch on the very next driven beat, after one cycle in flow-through mode and two in pipelined mode. A stale or early drive-enable flag shows as `dout_en` at the wrong level in the cycle after the deselect edge, or one cycle later. A wrong lane mask gives no sign until that word is read back, so every directed write is followed by a read of the same address.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;

   // kind of array access selected for the current edge
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_LOAD = 2'd1,
      ACC_NEXT = 2'd2,
      ACC_HOLD = 2'd3
   } acc_kind_e;

endpackage

// File: rtl/sbs_burst_gen.sv
`timescale 1ns/1ps
module sbs_burst_gen
   import sbs_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic              ce_n,
   input  logic              ce,
   input  logic              start_a_n,
   input  logic              start_b_n,
   input  logic              step_n,
   input  logic              linear_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              access
);

   localparam int HI_W = ADDR_W - BURST_W;

   if (BURST_W < 1 || BURST_W >= ADDR_W) begin : g_bad_burst
      $error("sbs_burst_gen: BURST_W must be between 1 and ADDR_W-1");
   end

   logic               active_q;
   logic [ADDR_W-1:0]  base_q;
   logic [BURST_W-1:0] cnt_q;
   logic [BURST_W-1:0] cnt_d;
   logic [ADDR_W-1:0]  base_eff;
   logic [BURST_W-1:0] low_lin;
   logic [BURST_W-1:0] low_ilv;
   logic               strobe;
   logic               chosen;
   acc_kind_e          kind;

   always_comb begin
      strobe = !start_a_n || !start_b_n;
      chosen = !ce_n && ce;
      kind   = ACC_NONE;
      if (sleep) begin
         kind = ACC_NONE;
      end else if (strobe) begin
         kind = chosen ? ACC_LOAD : ACC_NONE;
      end else if (active_q) begin
         kind = step_n ? ACC_HOLD : ACC_NEXT;
      end
   end

   always_comb begin
      unique case (kind)
         ACC_LOAD: cnt_d = '0;
         ACC_NEXT: cnt_d = cnt_q + 1'b1;
         default:  cnt_d = cnt_q;
      endcase
      base_eff = (kind == ACC_LOAD) ? addr : base_q;
      low_lin  = base_eff[BURST_W-1:0] + cnt_d;
      low_ilv  = base_eff[BURST_W-1:0] ^ cnt_d;
      acc_addr = {base_eff[ADDR_W-1:BURST_W], (linear_n ? low_ilv : low_lin)};
      access   = (kind != ACC_NONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         base_q   <= '0;
         cnt_q    <= '0;
      end else begin
         cnt_q <= cnt_d;
         if (kind == ACC_LOAD) begin
            base_q <= addr;
         end
         if (sleep) begin
            active_q <= 1'b0;
         end else if (strobe) begin
            active_q <= chosen;
         end
      end
   end

   logic [HI_W-1:0] unused_hi;
   assign unused_hi = base_q[ADDR_W-1:BURST_W];

   // R3 R4: each advance moves the beat counter on by exactly one
   p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == ACC_NEXT) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R12: a hold cycle keeps the beat counter where it was
   p_hold_beat_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == ACC_HOLD) |=> $stable(cnt_q));

   // R7: a strobe without both enables ends the burst
   p_desel_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !chosen && !sleep) |=> !active_q);

endmodule

// File: rtl/sbs_lane_mask.sv
`timescale 1ns/1ps
module sbs_lane_mask #(
   parameter int LANES = 4
) (
   input  logic             access,
   input  logic             wr_all_n,
   input  logic             wr_en_n,
   input  logic [LANES-1:0] lane_wr_n,
   output logic             is_write,
   output logic [LANES-1:0] lane_we
);

   if (LANES < 1) begin : g_bad_lanes
      $error("sbs_lane_mask: LANES must be at least 1");
   end

   logic glob;
   logic part;

   assign glob     = !wr_all_n;
   assign part     = !wr_en_n;
   assign is_write = access && (glob || part);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_we[i] = access && (glob || (part && !lane_wr_n[i]));
   end

endmodule

// File: rtl/sbs_out_stage.sv
`timescale 1ns/1ps
module sbs_out_stage #(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic              pipe_mode,
   input  logic              oe_n,
   input  logic              rd_go,
   input  logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);

   if (DATA_W < 1) begin : g_bad_width
      $error("sbs_out_stage: DATA_W must be at least 1");
   end

   logic              en1_q;
   logic              en2_q;
   logic [DATA_W-1:0] dq_q;
   logic              drive_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en1_q <= 1'b0;
         en2_q <= 1'b0;
         dq_q  <= '0;
      end else if (sleep) begin
         en1_q <= 1'b0;
         en2_q <= 1'b0;
      end else begin
         en1_q <= rd_go;
         en2_q <= en1_q;
         if (en1_q) begin
            dq_q <= rd_word;
         end
      end
   end

   always_comb begin
      drive_raw = pipe_mode ? en2_q : (en1_q || en2_q);
      dout      = pipe_mode ? dq_q : rd_word;
      dout_en   = drive_raw && !oe_n && !sleep;
   end

   // R8: the drive outlives the last read by one edge
   p_dcd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(en1_q) && !$past(sleep)) |-> drive_raw);

   // R8: two edges without a read leave the drive off
   p_dcd_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(en1_q) && !en1_q) |-> !drive_raw);

   // R10: an edge seen while asleep clears both drive stages
   p_sleep_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> (!en1_q && !en2_q));

endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram #(
   parameter int ADDR_W  = 6,
   parameter int LANES   = 4,
   parameter int LANE_W  = 9,
   parameter int BURST_W = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         addr,
   input  logic                      ce_n,
   input  logic                      ce,
   input  logic                      start_a_n,
   input  logic                      start_b_n,
   input  logic                      step_n,
   input  logic                      wr_all_n,
   input  logic                      wr_en_n,
   input  logic [LANES-1:0]          lane_wr_n,
   input  logic [LANES*LANE_W-1:0]   din,
   input  logic                      oe_n,
   input  logic                      sleep,
   input  logic                      pipe_mode,
   input  logic                      linear_n,
   output logic [LANES*LANE_W-1:0]   dout,
   output logic                      dout_en
);

   localparam int DEPTH  = 1 << ADDR_W;
   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_depth
      $error("sync_burst_sram: ADDR_W must be between 2 and 12");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("sync_burst_sram: LANE_W must be at least 1");
   end

   logic [ADDR_W-1:0] acc_addr;
   logic              access;
   logic              is_write;
   logic [LANES-1:0]  lane_we;
   logic              rd_go;
   logic [ADDR_W-1:0] rd_addr_q;
   logic [DATA_W-1:0] rd_word;

   sbs_burst_gen #(
      .ADDR_W (ADDR_W),
      .BURST_W(BURST_W)
   ) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .sleep    (sleep),
      .ce_n     (ce_n),
      .ce       (ce),
      .start_a_n(start_a_n),
      .start_b_n(start_b_n),
      .step_n   (step_n),
      .linear_n (linear_n),
      .addr     (addr),
      .acc_addr (acc_addr),
      .access   (access)
   );

   sbs_lane_mask #(
      .LANES(LANES)
   ) u_mask (
      .access   (access),
      .wr_all_n (wr_all_n),
      .wr_en_n  (wr_en_n),
      .lane_wr_n(lane_wr_n),
      .is_write (is_write),
      .lane_we  (lane_we)
   );

   assign rd_go = access && !is_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_addr_q <= '0;
      end else if (!sleep && rd_go) begin
         rd_addr_q <= acc_addr;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_bank
      logic [LANE_W-1:0] bank [DEPTH];

      always_ff @(posedge clk) begin
         if (lane_we[i]) begin
            bank[acc_addr] <= din[i*LANE_W +: LANE_W];
         end
      end

      assign rd_word[i*LANE_W +: LANE_W] = bank[rd_addr_q];

      // R6: a lane write lands at the beat address
      p_lane_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
         lane_we[i] |=> (bank[$past(acc_addr)] == $past(din[i*LANE_W +: LANE_W])));

      // R5: global write reaches this lane whatever its select says
      p_global_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (access && !wr_all_n) |=> (bank[$past(acc_addr)] == $past(din[i*LANE_W +: LANE_W])));
   end

   sbs_out_stage #(
      .DATA_W(DATA_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .sleep    (sleep),
      .pipe_mode(pipe_mode),
      .oe_n     (oe_n),
      .rd_go    (rd_go),
      .rd_word  (rd_word),
      .dout     (dout),
      .dout_en  (dout_en)
   );

   // R10: no array access is taken while asleep
   p_sleep_no_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (lane_we == '0));

endmodule

// File: tb/sync_burst_sram_test.sv
`timescale 1ns/1ps
module sync_burst_sram_test;

   localparam int AW = 6;
   localparam int LN = 4;
   localparam int LW = 9;
   localparam int DW = LN * LW;

   logic          clk = 1'b0;
   logic          b_rst_n;
   logic [AW-1:0] b_addr;
   logic          b_ce_n, b_ce, b_sa_n, b_sb_n, b_step_n;
   logic          b_all_n, b_wen_n;
   logic [LN-1:0] b_lane_n;
   logic [DW-1:0] b_din;
   logic          b_oe_n, b_sleep, b_pipe, b_lin_n;
   logic [DW-1:0] dout;
   logic          dout_en;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   logic [DW-1:0] refmem [64];
   logic          m_active, m_en1, m_en2;
   logic [AW-1:0] m_base, m_rda;
   logic [1:0]    m_cnt;
   logic [DW-1:0] m_dq;

   always #10 clk = ~clk;

   sync_burst_sram uut (
      .clk(clk), .rst_n(b_rst_n), .addr(b_addr), .ce_n(b_ce_n), .ce(b_ce),
      .start_a_n(b_sa_n), .start_b_n(b_sb_n), .step_n(b_step_n),
      .wr_all_n(b_all_n), .wr_en_n(b_wen_n), .lane_wr_n(b_lane_n), .din(b_din),
      .oe_n(b_oe_n), .sleep(b_sleep), .pipe_mode(b_pipe), .linear_n(b_lin_n),
      .dout(dout), .dout_en(dout_en)
   );

   function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] base, logic [1:0] n, logic lin_n);
      logic [1:0] lo;
      lo = lin_n ? (base[1:0] ^ n) : (base[1:0] + n);
      return {base[AW-1:2], lo};
   endfunction

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_active = 0; m_en1 = 0; m_en2 = 0;
      m_base = '0; m_rda = '0; m_cnt = '0; m_dq = '0;
   endtask

   task automatic model_edge();
      logic acc, wr;
      logic [AW-1:0] a;
      if (b_sleep) begin
         m_active = 0; m_en1 = 0; m_en2 = 0;
         return;
      end
      acc = 0;
      if (!b_sa_n || !b_sb_n) begin
         if (!b_ce_n && b_ce) begin
            m_base = b_addr; m_cnt = 0; m_active = 1; acc = 1;
         end else begin
            m_active = 0;
         end
      end else if (m_active) begin
         if (!b_step_n) m_cnt = m_cnt + 2'd1;
         acc = 1;
      end
      a  = beat_addr(m_base, m_cnt, b_lin_n);
      wr = acc && (!b_all_n || !b_wen_n);
      if (m_en1) m_dq = refmem[m_rda];
      m_en2 = m_en1;
      m_en1 = acc && !wr;
      if (m_en1) m_rda = a;
      if (wr) begin
         for (int i = 0; i < LN; i++) begin
            if (!b_all_n || !b_lane_n[i]) refmem[a][i*LW +: LW] = b_din[i*LW +: LW];
         end
      end
   endtask

   task automatic compare(input string tag);
      logic exp_en;
      logic [DW-1:0] exp_d;
      exp_en = !b_oe_n && !b_sleep && (b_pipe ? m_en2 : (m_en1 || m_en2));
      exp_d  = b_pipe ? m_dq : refmem[m_rda];
      check({tag, " drive"}, {{(DW-1){1'b0}}, dout_en}, {{(DW-1){1'b0}}, exp_en});
      if (exp_en) check({tag, " data"}, dout, exp_d);
   endtask

   task automatic tick(input string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic set_idle();
      b_sa_n = 1; b_sb_n = 1; b_step_n = 1; b_ce_n = 0; b_ce = 1;
      b_all_n = 1; b_wen_n = 1; b_lane_n = '1; b_oe_n = 0; b_sleep = 0;
   endtask

   task automatic cmd_read(input logic [AW-1:0] a);
      set_idle(); b_sa_n = 0; b_addr = a;
   endtask

   task automatic cmd_desel();
      set_idle(); b_sb_n = 0; b_ce_n = 1;
   endtask

   task automatic cmd_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic all_n, input logic wen_n, input logic [LN-1:0] ln);
      set_idle(); b_sb_n = 0; b_addr = a; b_din = d;
      b_all_n = all_n; b_wen_n = wen_n; b_lane_n = ln;
   endtask

   task automatic do_reset(input logic pipe, input logic lin_n);
      @(negedge clk);
      set_idle();
      b_rst_n = 0; b_pipe = pipe; b_lin_n = lin_n;
      repeat (2) @(negedge clk);
      check("R11 reset drive", {{(DW-1){1'b0}}, dout_en}, '0);
      b_rst_n = 1;
      model_reset();
   endtask

   task automatic fill();
      for (int base = 0; base < 64; base += 4) begin
         cmd_write(AW'(base), {$urandom, $urandom}, 0, 1, '1);
         tick("R5 fill");
         for (int k = 1; k < 4; k++) begin
            set_idle(); b_step_n = 0; b_all_n = 0; b_din = {$urandom, $urandom};
            tick("R5 fill");
         end
         cmd_desel(); tick("R5 fill");
      end
      set_idle(); tick("R5 fill");
   endtask

   task automatic suite(input logic pipe, input logic lin_n);
      string ordtag, modetag;
      ordtag  = lin_n ? "R4" : "R3";
      modetag = pipe ? "R2" : "R1";
      do_reset(pipe, lin_n);

      // burst read from a base with nonzero low bits
      cmd_read(6'd9); tick(ordtag);
      for (int k = 0; k < 3; k++) begin set_idle(); b_step_n = 0; tick(ordtag); end
      cmd_desel(); tick("R8");
      set_idle(); tick("R8"); tick("R8");

      // suspend repeats the current beat
      cmd_read(6'd22); tick("R12");
      set_idle(); tick("R12"); tick("R12");
      b_step_n = 0; tick("R12");
      cmd_desel(); tick("R12"); set_idle(); tick("R12"); tick("R12");

      // lane write: lanes 0 and 2 only
      cmd_write(6'd33, {$urandom, $urandom}, 1, 0, 4'b1010); tick("R6");
      cmd_desel(); tick("R6");
      cmd_read(6'd33); tick("R6");
      cmd_desel(); tick("R6"); set_idle(); tick("R6"); tick("R6");

      // global write ignores the lane selects
      cmd_write(6'd34, {$urandom, $urandom}, 0, 1, 4'b1111); tick("R5");
      cmd_read(6'd34); tick("R5");
      cmd_desel(); tick("R5"); set_idle(); tick("R5"); tick("R5");

      // strobes without both chip enables
      cmd_read(6'd12); b_ce_n = 1; tick("R7");
      cmd_read(6'd13); b_ce = 0; tick("R7");
      set_idle(); tick("R7"); tick("R7");

      // asynchronous output enable
      cmd_read(6'd40); tick(modetag);
      set_idle(); tick(modetag); tick(modetag);
      b_oe_n = 1; #2;
      check("R9 oe off", {{(DW-1){1'b0}}, dout_en}, '0);
      b_oe_n = 0; #2;
      check("R9 oe back", {{(DW-1){1'b0}}, dout_en}, {{(DW-1){1'b0}}, 1'b1});
      check("R9 data kept", dout, refmem[40]);
      cmd_desel(); tick("R9"); set_idle(); tick("R9"); tick("R9");

      // sleep gates drive and swallows a write
      cmd_read(6'd44); tick("R10");
      set_idle(); tick("R10"); tick("R10");
      b_sleep = 1; #2;
      check("R10 sleep off", {{(DW-1){1'b0}}, dout_en}, '0);
      b_sa_n = 0; b_addr = 6'd44; b_all_n = 0; b_din = '1;
      tick("R10"); tick("R10");
      set_idle(); tick("R10"); tick("R10");
      cmd_read(6'd44); tick("R10");
      cmd_desel(); tick("R10"); set_idle(); tick("R10"); tick("R10");

      // random traffic
      for (int c = 0; c < 300; c++) begin
         int r;
         r = int'($urandom % 16);
         set_idle();
         if (r < 4) begin
            b_sa_n = 0; b_addr = AW'($urandom);
         end else if (r < 6) begin
            b_sb_n = 0; b_addr = AW'($urandom); b_din = {$urandom, $urandom};
            b_all_n = $urandom % 2; b_wen_n = 0; b_lane_n = LN'($urandom);
         end else if (r == 6) begin
            b_sb_n = 0; if ($urandom % 2) b_ce_n = 1; else b_ce = 0;
         end else if (r < 13) begin
            b_step_n = 0;
            if ($urandom % 4 == 0) begin
               b_din = {$urandom, $urandom}; b_all_n = $urandom % 2; b_wen_n = 0;
               b_lane_n = LN'($urandom);
            end
         end
         if ($urandom % 16 == 0) b_oe_n = 1;
         if ($urandom % 40 == 0) b_sleep = 1;
         tick(modetag);
      end
      cmd_desel(); tick(modetag); set_idle(); tick(modetag); tick(modetag);
   endtask

   initial begin
      #(20ns * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 64; i++) refmem[i] = '0;
      b_addr = '0; b_din = '0; b_pipe = 1; b_lin_n = 1; b_rst_n = 0;
      set_idle();
      do_reset(1'b1, 1'b1);
      fill();
      suite(1'b1, 1'b1);
      suite(1'b1, 1'b0);
      suite(1'b0, 1'b1);
      suite(1'b0, 1'b0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule